// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block keeps the tag state of a set-associative cache. For each way of each set it stores an occupied flag, the line's tag and a two-bit access permission. A controller issues one operation per cycle on line addresses: it can check an access for a load, an instruction fetch or a store, test presence, test whether a set can take a line, allocate or free a line, read or change a permission, and ask which line should be evicted. The block holds no data. It answers with a hit flag, a way number, a permission or a line address.

A hit needs both a tag match and a permission that allows the request type. A line whose permission is the not-present code does not match, and it counts as a free slot. Each set keeps a true least-recently-used order. Every matching access moves the touched way to the front of that order, and so does every allocation. The eviction probe reports the way at the back of the order.

Top module: `perm_tag_dir`

## Requirements
- R1: The set index is address bits [OFFSET_W +: log2(SETS)], where SETS = LINES / WAYS, and the tag is the bits above it. Offset bits have no effect, and lines in different sets do not interact.
- R2: A way matches a request only if it is occupied, its tag equals the request tag and its permission is not 0. Presence (op 1) returns hit_o = match and way_o = the lowest matching way, or 0 when nothing matches.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only and 3 read-write. Request types are 0 load, 1 fetch and 2 store. An access (op 0) hits on a match with permission 3, or with permission 2 and a load or fetch. A store to a read-only line misses. When a line matches, way_o and perm_o report it.
- R4: Any matching access makes that way most recently used, even when the access misses on permission.
- R5: Availability (op 2) returns hit_o = 1 when some way of the set is unoccupied, has permission 0, or is occupied with the same tag.
- R6: Allocation (op 3) writes the lowest way that is unoccupied or has permission 0. It stores the tag, sets the permission to 1, makes the way most recently used and reports it on way_o.
- R7: Allocation with no free way, or with the tag already matching, sets err_o and changes no state. An error response has hit_o = 0, way_o = 0, perm_o = 0 and addr_o = 0.
- R8: Deallocation (op 4) clears the occupied flag of the matching way and reports that way. With no match it sets err_o and changes nothing.
- R9: Permission read (op 5) returns the matching way's permission on perm_o. Permission write (op 6) stores perm_i into the matching way. Both set err_o when nothing matches.
- R10: Probe (op 7) is legal only when availability is false. It returns the least-recently-used way on way_o and that line's address, with zero offset bits, on addr_o. When availability is true it sets err_o.
- R11: Replacement is true LRU. The probe victim is the way whose last touch, by a matching access or an allocation, is the oldest in the set. After reset, way WAYS-1 is the oldest.
- R12: rsp_valid_o is high exactly one cycle after req_valid_i, and each result is registered at that edge. After reset every way is unoccupied and all outputs are 0. Fields an operation does not define read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one operation per cycle |
| op_i | input | 3 | Operation code: 0 access, 1 present, 2 avail, 3 alloc, 4 dealloc, 5 perm read, 6 perm write, 7 probe |
| addr_i | input | ADDR_W | Line address of the request |
| req_type_i | input | 2 | Access type: 0 load, 1 fetch, 2 store |
| perm_i | input | 2 | Permission for perm write |
| rsp_valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Hit, presence or availability result |
| err_o | output | 1 | Illegal operation, state unchanged |
| way_o | output | log2(WAYS) | Way reported by the operation |
| perm_o | output | 2 | Permission of the matching line |
| addr_o | output | ADDR_W | Victim line address from a probe |

## Verification
Every result is due at the first rising edge after the request edge, and any state change is visible to the very next request. The bench applies each request at a falling edge and samples all outputs 1 ns after the following rising edge. It compares the whole response word against a tag, permission and age model that it keeps itself. Back-to-back requests therefore test that each update is seen immediately. Idle cycles are checked to confirm that no response appears without a request.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_INV  = 2'd1,
    PERM_RO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    REQ_LOAD  = 2'd0,
    REQ_FETCH = 2'd1,
    REQ_STORE = 2'd2
  } req_e;

  typedef enum logic [2:0] {
    OP_ACCESS  = 3'd0,
    OP_PRESENT = 3'd1,
    OP_AVAIL   = 3'd2,
    OP_ALLOC   = 3'd3,
    OP_DEALLOC = 3'd4,
    OP_PERM_RD = 3'd5,
    OP_PERM_WR = 3'd6,
    OP_PROBE   = 3'd7
  } op_e;
endpackage

// File: rtl/ptd_tag_store.sv
module ptd_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SET_W-1:0]            rd_set_i,
  output logic [WAYS-1:0]             rd_vld_o,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  output logic [WAYS-1:0][1:0]        rd_perm_o,
  input  logic                        wr_en_i,
  input  logic [SET_W-1:0]            wr_set_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic                        wr_vld_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [1:0]                  wr_perm_i
);
  logic             vld_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [1:0]       perm_q [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[s][w]  <= 1'b0;
          tag_q[s][w]  <= '0;
          perm_q[s][w] <= '0;
        end else if (wr_en_i && wr_set_i == SET_W'(s) && wr_way_i == WAY_W'(w)) begin
          vld_q[s][w]  <= wr_vld_i;
          tag_q[s][w]  <= wr_tag_i;
          perm_q[s][w] <= wr_perm_i;
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_vld_o[w]  = vld_q[rd_set_i][w];
      rd_tag_o[w]  = tag_q[rd_set_i][w];
      rd_perm_o[w] = perm_q[rd_set_i][w];
    end
  end
endmodule

// File: rtl/ptd_lru.sv
module ptd_lru #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        touch_i,
  input  logic [SET_W-1:0]            touch_set_i,
  input  logic [WAY_W-1:0]            touch_way_i,
  input  logic [SET_W-1:0]            rd_set_i,
  output logic [WAYS-1:0][WAY_W-1:0]  rd_age_o,
  output logic [WAY_W-1:0]            victim_o
);
  // age 0 = most recent, WAYS-1 = least recent; each set holds a permutation
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic [WAY_W-1:0] ref_age [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    assign ref_age[s] = age_q[s][touch_way_i];
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          age_q[s][w] <= WAY_W'(w);
        end else if (touch_i && touch_set_i == SET_W'(s)) begin
          if (touch_way_i == WAY_W'(w))
            age_q[s][w] <= '0;
          else if (age_q[s][w] < ref_age[s])
            age_q[s][w] <= age_q[s][w] + WAY_W'(1);
        end
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      rd_age_o[w] = age_q[rd_set_i][w];
      if (age_q[rd_set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ptd_way_match.sv
module ptd_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [WAYS-1:0]             row_vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag_i,
  input  logic [WAYS-1:0][1:0]        row_perm_i,
  output logic                        match_o,
  output logic [WAY_W-1:0]            match_way_o,
  output logic [1:0]                  match_perm_o,
  output logic                        same_o,
  output logic                        free_o,
  output logic [WAY_W-1:0]            free_way_o
);
  logic [WAYS-1:0] match_vec, same_vec, free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign same_vec[w]  = row_vld_i[w] && (row_tag_i[w] == tag_i);
    assign match_vec[w] = same_vec[w] && (row_perm_i[w] != 2'd0);
    assign free_vec[w]  = !row_vld_i[w] || (row_perm_i[w] == 2'd0);
  end

  // lowest index wins
  always_comb begin
    match_way_o = '0;
    free_way_o  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) match_way_o = WAY_W'(w);
      if (free_vec[w])  free_way_o  = WAY_W'(w);
    end
  end

  assign match_o      = |match_vec;
  assign same_o       = |same_vec;
  assign free_o       = |free_vec;
  assign match_perm_o = row_perm_i[match_way_o];
endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir
  import ptd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int LINES    = 256,
  parameter int WAYS     = 4,
  localparam int SETS  = LINES / WAYS,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFFSET_W - SET_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        req_type_i,
  input  logic [1:0]        perm_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              err_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [1:0]        perm_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             offset_unused;

  assign set_idx       = addr_i[OFFSET_W +: SET_W];
  assign req_tag       = addr_i[ADDR_W-1 -: TAG_W];
  assign offset_unused = ^addr_i[OFFSET_W-1:0];

  logic [WAYS-1:0]             row_vld;
  logic [WAYS-1:0][TAG_W-1:0]  row_tag;
  logic [WAYS-1:0][1:0]        row_perm;
  logic [WAYS-1:0][WAY_W-1:0]  lru_age_row;
  logic [WAY_W-1:0]            victim_way;

  logic             match, same, free;
  logic [WAY_W-1:0] match_way, free_way;
  logic [1:0]       match_perm;

  logic             wr_en, wr_vld;
  logic [WAY_W-1:0] wr_way;
  logic [TAG_W-1:0] wr_tag;
  logic [1:0]       wr_perm;
  logic             touch;
  logic [WAY_W-1:0] touch_way;

  ptd_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_set_i  (set_idx),
    .rd_vld_o  (row_vld),
    .rd_tag_o  (row_tag),
    .rd_perm_o (row_perm),
    .wr_en_i   (wr_en),
    .wr_set_i  (set_idx),
    .wr_way_i  (wr_way),
    .wr_vld_i  (wr_vld),
    .wr_tag_i  (wr_tag),
    .wr_perm_i (wr_perm)
  );

  ptd_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_set_i (set_idx),
    .touch_way_i (touch_way),
    .rd_set_i    (set_idx),
    .rd_age_o    (lru_age_row),
    .victim_o    (victim_way)
  );

  ptd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tag_i        (req_tag),
    .row_vld_i    (row_vld),
    .row_tag_i    (row_tag),
    .row_perm_i   (row_perm),
    .match_o      (match),
    .match_way_o  (match_way),
    .match_perm_o (match_perm),
    .same_o       (same),
    .free_o       (free),
    .free_way_o   (free_way)
  );

  logic              n_hit, n_err;
  logic [WAY_W-1:0]  n_way;
  logic [1:0]        n_perm;
  logic [ADDR_W-1:0] n_addr;

  always_comb begin
    wr_en     = 1'b0;
    wr_vld    = 1'b1;
    wr_way    = match_way;
    wr_tag    = req_tag;
    wr_perm   = match_perm;
    touch     = 1'b0;
    touch_way = match_way;
    n_hit     = 1'b0;
    n_err     = 1'b0;
    n_way     = '0;
    n_perm    = '0;
    n_addr    = '0;
    case (op_i)
      OP_ACCESS: if (match) begin
        touch  = 1'b1;
        n_way  = match_way;
        n_perm = match_perm;
        n_hit  = (match_perm == PERM_RW) ||
                 (match_perm == PERM_RO &&
                  (req_type_i == REQ_LOAD || req_type_i == REQ_FETCH));
      end
      OP_PRESENT: if (match) begin
        n_hit = 1'b1;
        n_way = match_way;
      end
      OP_AVAIL: n_hit = same || free;
      OP_ALLOC: begin
        if (!free || match) begin
          n_err = 1'b1;
        end else begin
          wr_en     = 1'b1;
          wr_way    = free_way;
          wr_perm   = PERM_INV;
          touch     = 1'b1;
          touch_way = free_way;
          n_way     = free_way;
        end
      end
      OP_DEALLOC: begin
        if (!match) n_err = 1'b1;
        else begin
          wr_en  = 1'b1;
          wr_vld = 1'b0;
          n_way  = match_way;
        end
      end
      OP_PERM_RD: begin
        if (!match) n_err = 1'b1;
        else begin
          n_perm = match_perm;
          n_way  = match_way;
        end
      end
      OP_PERM_WR: begin
        if (!match) n_err = 1'b1;
        else begin
          wr_en   = 1'b1;
          wr_perm = perm_i;
          n_way   = match_way;
        end
      end
      OP_PROBE: begin
        if (same || free) n_err = 1'b1;
        else begin
          n_way  = victim_way;
          n_addr = {row_tag[victim_way], set_idx, {OFFSET_W{1'b0}}};
        end
      end
      default: ;
    endcase
    if (!req_valid_i) begin
      wr_en = 1'b0;
      touch = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      err_o       <= 1'b0;
      way_o       <= '0;
      perm_o      <= '0;
      addr_o      <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        hit_o  <= n_hit;
        err_o  <= n_err;
        way_o  <= n_way;
        perm_o <= n_perm;
        addr_o <= n_addr;
      end
    end
  end
endmodule

// File: rtl/ptd_chk.sv
module ptd_chk
  import ptd_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic [2:0]                 op_i,
  input logic [1:0]                 req_type_i,
  input logic                       rsp_valid_o,
  input logic                       hit_o,
  input logic                       err_o,
  input logic [WAY_W-1:0]           way_o,
  input logic [1:0]                 perm_o,
  input logic [WAYS-1:0][WAY_W-1:0] age_row_i
);
  logic [WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) age_seen[age_row_i[w]] = 1'b1;
  end

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R3
  store_needs_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == OP_ACCESS && req_type_i == REQ_STORE) |=> (!hit_o || perm_o == PERM_RW));

  // R3
  hit_needs_readable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == OP_ACCESS) |=> (!hit_o || perm_o[1]));

  // R7
  query_never_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op_i == OP_ACCESS || op_i == OP_PRESENT || op_i == OP_AVAIL)) |=> !err_o);

  // R7
  err_fields_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && err_o) |-> (!hit_o && way_o == '0 && perm_o == 2'd0));

  // R11
  lru_is_permutation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &age_seen);
endmodule

bind perm_tag_dir ptd_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .op_i        (op_i),
  .req_type_i  (req_type_i),
  .rsp_valid_o (rsp_valid_o),
  .hit_o       (hit_o),
  .err_o       (err_o),
  .way_o       (way_o),
  .perm_o      (perm_o),
  .age_row_i   (lru_age_row)
);

// File: tb/perm_tag_dir_bench.sv
module perm_tag_dir_bench;
  localparam int AW = 12;
  localparam int OW = 4;
  localparam int LN = 8;
  localparam int WY = 4;
  localparam int ST = LN / WY;
  localparam int WW = 2;
  localparam int RW = 3 + WW + 2 + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [1:0] rtype = '0;
  logic [1:0] perm = '0;
  logic rsp_valid, hit, err;
  logic [WW-1:0] way;
  logic [1:0] perm_out;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit mv [ST][WY];
  int mt [ST][WY];
  int mp [ST][WY];
  int ma [ST][WY];

  perm_tag_dir #(.ADDR_W(AW), .OFFSET_W(OW), .LINES(LN), .WAYS(WY)) u_perm_tag_dir (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .op_i(op), .addr_i(addr),
    .req_type_i(rtype), .perm_i(perm), .rsp_valid_o(rsp_valid), .hit_o(hit), .err_o(err),
    .way_o(way), .perm_o(perm_out), .addr_o(addr_out)
  );

  always #2ns clk = ~clk;

  function automatic int mk(int tag, int s, int off);
    return (tag << (OW + 1)) | (s << OW) | off;
  endfunction

  task automatic check(string rq, string what, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic touch(int s, int w);
    int r = ma[s][w];
    for (int i = 0; i < WY; i++) begin
      if (i == w) ma[s][i] = 0;
      else if (ma[s][i] < r) ma[s][i]++;
    end
  endtask

  task automatic run_op(int o, int a, int rt, int pm, string rq);
    int s = (a >> OW) & (ST - 1);
    int t = (a >> (OW + 1)) & 127;
    int mw = -1, fw = -1, vic = 0;
    bit same = 0;
    int e_hit = 0, e_err = 0, e_way = 0, e_perm = 0, e_addr = 0;
    for (int w = 0; w < WY; w++) begin
      if (mv[s][w] && mt[s][w] == t) begin
        same = 1;
        if (mp[s][w] != 0 && mw < 0) mw = w;
      end
      if ((!mv[s][w] || mp[s][w] == 0) && fw < 0) fw = w;
      if (ma[s][w] == WY - 1) vic = w;
    end
    case (o)
      0: if (mw >= 0) begin
        e_way = mw; e_perm = mp[s][mw];
        e_hit = (e_perm == 3 || (e_perm == 2 && rt != 2)) ? 1 : 0;
        touch(s, mw);
      end
      1: if (mw >= 0) begin e_hit = 1; e_way = mw; end
      2: e_hit = (same || fw >= 0) ? 1 : 0;
      3: if (fw < 0 || mw >= 0) e_err = 1;
         else begin mv[s][fw] = 1; mt[s][fw] = t; mp[s][fw] = 1; touch(s, fw); e_way = fw; end
      4: if (mw < 0) e_err = 1; else begin mv[s][mw] = 0; e_way = mw; end
      5: if (mw < 0) e_err = 1; else begin e_perm = mp[s][mw]; e_way = mw; end
      6: if (mw < 0) e_err = 1; else begin mp[s][mw] = pm; e_way = mw; end
      default: if (same || fw >= 0) e_err = 1;
               else begin e_way = vic; e_addr = mk(mt[s][vic], s, 0); end
    endcase
    @(negedge clk);
    req_valid = 1'b1; op = 3'(o); addr = AW'(a); rtype = 2'(rt); perm = 2'(pm);
    @(posedge clk);
    #1ns;
    check(rq, $sformatf("op%0d addr %h", o, a), {rsp_valid, hit, err, way, perm_out, addr_out},
          {1'b1, 1'(e_hit), 1'(e_err), WW'(e_way), 2'(e_perm), AW'(e_addr)});
  endtask

  task automatic idle_check(string rq);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1ns;
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: actual rsp_valid %b expected 0", rq, rsp_valid);
    end
  endtask

  initial begin
    for (int s = 0; s < ST; s++)
      for (int w = 0; w < WY; w++) begin mv[s][w] = 0; mt[s][w] = 0; mp[s][w] = 0; ma[s][w] = w; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    check("R12", "reset outputs", {rsp_valid, hit, err, way, perm_out, addr_out}, '0);
    for (int s = 0; s < ST; s++) begin
      run_op(2, mk(1, s, 0), 0, 0, "R12");
      run_op(1, mk(1, s, 0), 0, 0, "R2");
      run_op(7, mk(1, s, 0), 0, 0, "R10");
    end
    // R6: fill ways in order
    for (int s = 0; s < ST; s++)
      for (int w = 0; w < WY; w++) run_op(3, mk(10 + w, s, 0), 0, 0, "R6");
    // R7: full set and duplicate
    run_op(3, mk(20, 0, 0), 0, 0, "R7");
    run_op(3, mk(10, 0, 3), 0, 0, "R7");
    run_op(1, mk(20, 0, 0), 0, 0, "R7");
    // R5
    run_op(2, mk(20, 0, 0), 0, 0, "R5");
    run_op(2, mk(11, 0, 9), 0, 0, "R5");
    run_op(7, mk(20, 0, 0), 0, 0, "R10");
    // R11: touch order 2,0,3,1
    for (int w = 0; w < WY; w++) run_op(6, mk(10 + w, 0, 0), 0, 3, "R9");
    run_op(0, mk(12, 0, 5), 0, 0, "R11");
    run_op(0, mk(10, 0, 5), 1, 0, "R11");
    run_op(0, mk(13, 0, 5), 2, 0, "R11");
    run_op(0, mk(11, 0, 5), 0, 0, "R11");
    run_op(7, mk(30, 0, 0), 0, 0, "R11");
    // R3 / R1: permission x request type sweep, nonzero offsets
    for (int pm = 1; pm < 4; pm++) begin
      run_op(6, mk(10, 1, 0), 0, pm, "R9");
      run_op(5, mk(10, 1, 7), 0, 0, "R9");
      for (int rt = 0; rt < 3; rt++) run_op(0, mk(10, 1, rt * 5), rt, 0, "R3");
    end
    run_op(1, mk(10, 0, 15), 0, 0, "R1");
    // R2: not-present line no longer matches and is free
    run_op(6, mk(10, 1, 0), 0, 0, "R9");
    run_op(0, mk(10, 1, 0), 0, 0, "R2");
    run_op(1, mk(10, 1, 0), 0, 0, "R2");
    run_op(2, mk(31, 1, 0), 0, 0, "R5");
    run_op(3, mk(30, 1, 0), 0, 0, "R6");
    // R4: store to invalid line misses yet becomes MRU
    run_op(0, mk(13, 1, 0), 2, 0, "R4");
    run_op(0, mk(11, 1, 0), 2, 0, "R4");
    run_op(7, mk(40, 1, 0), 0, 0, "R4");
    // R8
    run_op(4, mk(12, 1, 0), 0, 0, "R8");
    run_op(4, mk(12, 1, 0), 0, 0, "R8");
    run_op(5, mk(12, 1, 0), 0, 0, "R9");
    run_op(6, mk(12, 1, 0), 0, 3, "R9");
    run_op(7, mk(12, 1, 0), 0, 0, "R10");
    run_op(2, mk(40, 1, 0), 0, 0, "R5");
    idle_check("R12");
    // mixed sweep
    begin
      int unsigned seed = 32'h1234_5678;
      string tags [8] = '{"R3", "R2", "R5", "R6", "R8", "R9", "R9", "R10"};
      for (int n = 0; n < 3000; n++) begin
        int o;
        seed = seed * 1103515245 + 12345;
        o = int'((seed >> 4) % 8);
        run_op(o, mk(int'((seed >> 8) % 6), int'((seed >> 12) % ST), int'((seed >> 14) % 16)),
               int'((seed >> 18) % 3), int'((seed >> 21) % 4), tags[o]);
      end
    end
    idle_check("R12");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule